// File: doc/BRIEF.md
# Serial Frame Builder

This block turns a host-supplied burst of 16-bit words into one serial frame on a bit-wide output link. Each frame opens with a fixed 6-bit start pattern whose bits are spread far apart. A Hamming-protected byte follows, carrying the word count and a flag that says whether a label is present. An optional 16-bit tag comes next, then the words themselves, and finally an optional CRC-16 computed over those words. The builder never looks inside the words, so any data type passes through unchanged.

The host opens a frame with a request handshake. The request carries the word count (0 to 7), a label-enable flag with the label value, and a CRC-enable flag. The words then arrive on a separate valid/ready stream. The builder fetches each word only when it can shift it out. Downstream, a link multiplexer takes bits through a valid/ready pair, and a start strobe marks the first header bit. Every field goes out most significant bit first.

Top module: `lft_frame_tx`

## Requirements
- R1: After reset the block shows `ser_valid_o`=0, `ser_sof_o`=0, `pay_ready_o`=0 and `req_ready_o`=1.
- R2: Every frame begins with the header pattern 101100 (left bit first). `ser_sof_o` is high only while that first header bit is offered, and it rises in the cycle after the request is accepted.
- R3: The second field is a byte built from d3=label flag and d2..d0=word count. Its parity bits are p1=d3^d2^d0, p2=d3^d1^d0 and p4=d2^d1^d0. The seven bits {p1,p2,d3,p4,d2,d1,d0} are sent first, followed by p0, the even parity of those seven.
- R4: When the label flag is set, the 16-bit label follows the length byte, MSB first. When the flag is clear, no label bits are sent.
- R5: Exactly the requested number of payload words follow, each unchanged and MSB first. `pay_ready_o` is asserted only while a request is in progress.
- R6: When CRC is enabled, the last 16 bits of the frame are the CRC over the payload words. The CRC uses polynomial 0x1021, starts from 0xFFFF, and takes each word MSB first with no reflection and no final XOR. When CRC is disabled, no CRC bits are sent.
- R7: A frame with a word count of 0 carries no payload words. If CRC is enabled, such a frame ends with 0xFFFF.
- R8: While `ser_ready_i` is low, `ser_valid_o` stays high and `ser_bit_o` holds its value. No bit is lost and no bit is repeated under any pattern of stalls.
- R9: `req_ready_o` is low from the cycle after a request is accepted until the final bit of that frame has transferred. A new request is accepted after that.
- R10: Gaps in `pay_valid_i` pause the output (`ser_valid_o` drops) but do not reorder or corrupt the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Frame request valid |
| req_ready_o | output | 1 | Builder idle, request can be taken |
| req_len_i | input | 3 | Payload word count, 0 to 7 |
| req_lbl_en_i | input | 1 | Append label after length byte |
| req_lbl_i | input | 16 | Label value |
| req_crc_en_i | input | 1 | Append CRC after payload |
| pay_valid_i | input | 1 | Payload word valid |
| pay_ready_o | output | 1 | Payload word taken this cycle if valid |
| pay_data_i | input | 16 | Payload word |
| ser_valid_o | output | 1 | Serial bit valid |
| ser_bit_o | output | 1 | Serial bit |
| ser_sof_o | output | 1 | First header bit strobe |
| ser_ready_i | input | 1 | Downstream accepts bit |

## Verification
Two things can happen in the same cycle. The last bit of one field can leave the shifter while the next field is loaded, and that next field may be a payload word fetched from the host. When the output is ready that cycle, the two handshakes overlap and the new word must follow with no gap and no repeated bit. This is provoked by keeping payload words presented ahead of need under a constantly ready output. It is provoked again under a pseudo-random stall pattern, where the final bit can be held back exactly at a field boundary. Each case is judged by comparing every captured bit against a frame the bench assembles from the requirements, and by checking that a stalled bit never changes.

// File: rtl/lft_pkg.sv
package lft_pkg;
  // field currently held in the shifter; F_END only appears as a next-field decision
  typedef enum logic [2:0] {F_IDLE, F_HDR, F_LT, F_LBL, F_PAY, F_CRC, F_END} fld_e;
endpackage

// File: rtl/lft_lt_enc.sv
module lft_lt_enc (
  input  logic [3:0] info_i,
  output logic [7:0] code_o
);
  logic d3, d2, d1, d0, p1, p2, p4, p0;
  logic [6:0] cw;

  always_comb begin
    {d3, d2, d1, d0} = info_i;
    p1 = d3 ^ d2 ^ d0;
    p2 = d3 ^ d1 ^ d0;
    p4 = d2 ^ d1 ^ d0;
    cw = {p1, p2, d3, p4, d2, d1, d0};
    p0 = ^cw;
    code_o = {cw, p0};
  end
endmodule

// File: rtl/lft_crc_acc.sv
module lft_crc_acc #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         upd_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;

  // whole word folded in one cycle, MSB first
  always_comb begin
    crc_d = crc_q;
    for (int i = W - 1; i >= 0; i--) begin
      if (crc_d[W-1] ^ data_i[i]) crc_d = {crc_d[W-2:0], 1'b0} ^ POLY;
      else                        crc_d = {crc_d[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (upd_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/lft_piso.sv
module lft_piso #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     data_i,   // left aligned
  input  logic [CNT_W-1:0] len_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= len_i;
    end else if (shift_i) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign bit_o = sh_q[W-1];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/lft_frame_tx.sv
module lft_frame_tx
  import lft_pkg::*;
#(
  parameter int unsigned  WORD_W   = 16,
  parameter int unsigned  LEN_W    = 3,
  parameter int unsigned  HDR_W    = 6,
  parameter logic [HDR_W-1:0]  HDR_CODE = 6'b101100,
  parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [WORD_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_lbl_en_i,
  input  logic [WORD_W-1:0] req_lbl_i,
  input  logic              req_crc_en_i,
  input  logic              pay_valid_i,
  output logic              pay_ready_o,
  input  logic [WORD_W-1:0] pay_data_i,
  output logic              ser_valid_o,
  output logic              ser_bit_o,
  output logic              ser_sof_o,
  input  logic              ser_ready_i
);
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
  localparam int unsigned INFO_W = LEN_W + 1;   // encoder is 4-in/8-out
  localparam int unsigned LT_W   = 2 * INFO_W;

  fld_e              fld_q, nxt, tail, load_fld;
  logic [LEN_W-1:0]  len_q, left_q;
  logic              lbl_en_q, crc_en_q;
  logic [WORD_W-1:0] lbl_q, crc_val, load_data;
  logic [CNT_W-1:0]  cnt, load_len;
  logic [LT_W-1:0]   lt_code;
  logic              busy, fire, slot, accept, load_go, shift, pay_take;

  lft_lt_enc u_lt_enc (
    .info_i (INFO_W'({lbl_en_q, len_q})),
    .code_o (lt_code)
  );

  lft_crc_acc #(.W(WORD_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .upd_i  (pay_take),
    .data_i (pay_data_i),
    .crc_o  (crc_val)
  );

  lft_piso #(.W(WORD_W), .CNT_W(CNT_W)) u_piso (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_go),
    .data_i (load_data),
    .len_i  (load_len),
    .shift_i(shift),
    .bit_o  (ser_bit_o),
    .cnt_o  (cnt)
  );

  assign busy        = (fld_q != F_IDLE);
  assign ser_valid_o = (cnt != '0);
  assign fire        = ser_valid_o && ser_ready_i;
  // next field may be loaded when the shifter is empty or its last bit leaves now
  assign slot        = busy && ((cnt == '0) || ((cnt == CNT_W'(1)) && fire));
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    tail = (left_q != '0) ? F_PAY : (crc_en_q ? F_CRC : F_END);
    unique case (fld_q)
      F_HDR:        nxt = F_LT;
      F_LT:         nxt = lbl_en_q ? F_LBL : tail;
      F_LBL, F_PAY: nxt = tail;
      F_CRC:        nxt = F_END;
      default:      nxt = F_END;
    endcase
  end

  assign pay_ready_o = slot && (nxt == F_PAY);
  assign pay_take    = pay_ready_o && pay_valid_i;
  assign load_go     = accept || (slot && (nxt != F_END) && ((nxt != F_PAY) || pay_valid_i));
  assign shift       = fire && !load_go;
  assign load_fld    = accept ? F_HDR : nxt;

  always_comb begin
    load_data = '0;
    load_len  = '0;
    unique case (load_fld)
      F_HDR: begin
        load_data = {HDR_CODE, {(WORD_W - HDR_W){1'b0}}};
        load_len  = CNT_W'(HDR_W);
      end
      F_LT: begin
        load_data = {lt_code, {(WORD_W - LT_W){1'b0}}};
        load_len  = CNT_W'(LT_W);
      end
      F_LBL: begin
        load_data = lbl_q;
        load_len  = CNT_W'(WORD_W);
      end
      F_PAY: begin
        load_data = pay_data_i;
        load_len  = CNT_W'(WORD_W);
      end
      F_CRC: begin
        load_data = crc_val;
        load_len  = CNT_W'(WORD_W);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q    <= F_IDLE;
      len_q    <= '0;
      left_q   <= '0;
      lbl_en_q <= 1'b0;
      crc_en_q <= 1'b0;
      lbl_q    <= '0;
    end else if (accept) begin
      fld_q    <= F_HDR;
      len_q    <= req_len_i;
      left_q   <= req_len_i;
      lbl_en_q <= req_lbl_en_i;
      crc_en_q <= req_crc_en_i;
      lbl_q    <= req_lbl_i;
    end else if (slot) begin
      if (nxt == F_END) begin
        fld_q <= F_IDLE;
      end else if (load_go) begin
        fld_q <= nxt;
        if (nxt == F_PAY) left_q <= left_q - LEN_W'(1);
      end
    end
  end

  assign ser_sof_o = ser_valid_o && (fld_q == F_HDR) && (cnt == CNT_W'(HDR_W));
endmodule

// File: rtl/lft_frame_tx_chk.sv
module lft_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic pay_ready_o,
  input logic ser_valid_o,
  input logic ser_bit_o,
  input logic ser_sof_o,
  input logic ser_ready_i
);
  p_sof_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sof_o |-> ser_valid_o);

  p_accept_sof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ser_sof_o);

  p_pay_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> !req_ready_o);

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && !ser_ready_i) |=> (ser_valid_o && $stable(ser_bit_o)));

  p_sof_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_sof_o && !ser_ready_i) |=> ser_sof_o);

  p_no_req_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> !req_ready_o);
endmodule

bind lft_frame_tx lft_frame_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .pay_ready_o (pay_ready_o),
  .ser_valid_o (ser_valid_o),
  .ser_bit_o   (ser_bit_o),
  .ser_sof_o   (ser_sof_o),
  .ser_ready_i (ser_ready_i)
);

// File: tb/lft_frame_tx_tb.sv
module lft_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_len = '0;
  logic        req_lbl_en = 1'b0, req_crc_en = 1'b0;
  logic [15:0] req_lbl = '0;
  logic        pay_valid = 1'b0, pay_ready;
  logic [15:0] pay_data = '0;
  logic        ser_valid, ser_bit, ser_sof;
  logic        ser_ready = 1'b1;

  int checks = 0, errors = 0, cycles = 0, stall_err = 0;
  bit rnd_ready = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit exp_q[$], cap_q[$];
  int sof_q[$];
  bit prev_stall = 0, prev_bit = 0;

  always #10 clk = ~clk;

  lft_frame_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_len_i(req_len),
    .req_lbl_en_i(req_lbl_en), .req_lbl_i(req_lbl), .req_crc_en_i(req_crc_en),
    .pay_valid_i(pay_valid), .pay_ready_o(pay_ready), .pay_data_i(pay_data),
    .ser_valid_o(ser_valid), .ser_bit_o(ser_bit), .ser_sof_o(ser_sof),
    .ser_ready_i(ser_ready)
  );

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_ready <= rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // capture monitor, samples before the next rising edge
  always begin
    @(negedge clk); #5;
    cycles++;
    if (rst_n) begin
      if (prev_stall && (!ser_valid || ser_bit != prev_bit)) stall_err++;
      if (ser_valid && ser_ready) begin
        cap_q.push_back(ser_bit);
        if (ser_sof) sof_q.push_back(cap_q.size() - 1);
      end
      prev_stall = ser_valid && !ser_ready;
      prev_bit   = ser_bit;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: got running exp finished");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] lt_byte(input bit lbl, input logic [2:0] n);
    logic p1, p2, p4;
    logic [6:0] c;
    p1 = lbl ^ n[2] ^ n[0];
    p2 = lbl ^ n[1] ^ n[0];
    p4 = n[2] ^ n[1] ^ n[0];
    c = {p1, p2, lbl, p4, n[2], n[1], n[0]};
    return {c, ^c};
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic push(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic run_frame(input logic [2:0] n, input bit lbl_en, input logic [15:0] lbl,
                           input bit crc_en, input int gap, input logic [15:0] seed,
                           input string tag);
    logic [15:0] w[8];
    logic [15:0] crc = 16'hFFFF;
    int t;
    int mism;
    exp_q.delete(); cap_q.delete(); sof_q.delete();
    for (int i = 0; i < 8; i++) w[i] = seed ^ (16'h1357 * 16'(i + 1));
    push(16'b101100, 6);
    push({8'h00, lt_byte(lbl_en, n)}, 8);
    if (lbl_en) push(lbl, 16);
    for (int i = 0; i < int'(n); i++) begin
      push(w[i], 16);
      crc = crc_step(crc, w[i]);
    end
    if (crc_en) push(crc, 16);

    @(negedge clk);
    req_len = n; req_lbl_en = lbl_en; req_lbl = lbl; req_crc_en = crc_en; req_valid = 1'b1;
    #5;
    while (!req_ready) begin @(negedge clk); #5; end
    @(negedge clk); req_valid = 1'b0;
    #5;
    chk(!req_ready, {tag, " R9 busy after accept"}, req_ready, 0);
    @(negedge clk);
    for (int i = 0; i < int'(n); i++) begin
      repeat (gap) @(negedge clk);
      pay_valid = 1'b1; pay_data = w[i];
      #5;
      while (!pay_ready) begin @(negedge clk); #5; end
      @(negedge clk); pay_valid = 1'b0;
    end
    t = 0;
    while (cap_q.size() < exp_q.size() && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    #7;
    chk(cap_q.size() == exp_q.size(), {tag, " length"}, cap_q.size(), exp_q.size());
    mism = -1;
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      if (mism < 0 && cap_q[i] != exp_q[i]) mism = i;
    chk(mism < 0, {tag, " bit stream (first mismatch index)"}, mism, -1);
    chk(sof_q.size() == 1 && sof_q[0] == 0, {tag, " R2 sof at first bit"},
        sof_q.size() == 0 ? -1 : sof_q[0], 0);
    chk(req_ready, {tag, " R9 ready after frame"}, req_ready, 1);
  endtask

  task automatic t_reset();
    #5;
    chk(!ser_valid, "R1 ser_valid", ser_valid, 0);
    chk(!ser_sof, "R1 ser_sof", ser_sof, 0);
    chk(!pay_ready, "R1 pay_ready", pay_ready, 0);
    chk(req_ready, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_basic();       run_frame(3'd3, 1, 16'hBEEF, 1, 0, 16'h4A21, "R2 R3 R4 R5 R6 basic"); endtask
  task automatic t_plain();       run_frame(3'd5, 0, 16'h1111, 0, 0, 16'h0F0F, "R4 R6 absent fields"); endtask
  task automatic t_empty_crc();   run_frame(3'd0, 0, 16'h0000, 1, 0, 16'h0000, "R7 empty crc FFFF"); endtask
  task automatic t_empty_bare();  run_frame(3'd0, 1, 16'h8001, 0, 0, 16'h0000, "R3 R7 empty label only"); endtask
  task automatic t_stall();
    rnd_ready = 1;
    run_frame(3'd7, 1, 16'h5A5A, 1, 0, 16'hC0DE, "R8 random stalls");
    run_frame(3'd2, 0, 16'h0000, 1, 1, 16'h7777, "R8 R10 stalls and gaps");
    rnd_ready = 0;
    chk(stall_err == 0, "R8 stalled bit held", stall_err, 0);
  endtask
  task automatic t_gaps();        run_frame(3'd4, 1, 16'h0102, 1, 3, 16'h9E37, "R10 payload gaps"); endtask
  task automatic t_back2back();
    run_frame(3'd1, 0, 16'h0000, 1, 0, 16'hFFFF, "R9 first of pair");
    run_frame(3'd6, 1, 16'hFFFF, 0, 0, 16'h0001, "R9 second of pair");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_plain();
    t_empty_crc();
    t_empty_bare();
    t_gaps();
    t_stall();
    t_back2back();
    summary();
  end
endmodule